// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block builds the byte the host reads from a flash-style memory while one of the memory's embedded program or erase operations runs. The program and erase engines report their state as level signals: program busy, sector-erase command window open, erase busy, and a time-limit failure pulse. From these the block selects what a read returns. While an operation is in progress the host sees a status byte instead of array data. That byte carries a completion flag, a bit that alternates on every read, a time-limit failure flag and an erase-window flag. When no operation is in progress, array read data passes straight through.

The bit positions in the status byte are fixed, because host polling code decodes them. Bit 7 is the completion flag. During programming it holds the inverse of bit 7 of the last byte written. During erase it holds 0. Bit 6 is the toggle. Bit 5 is the failure flag. Bit 3 is the erase flag. Bits 4 and 2..0 are 0. The engine raises its busy level only once its command sequence is complete, which is the point from which polling is valid: the fourth write strobe for a program, the sixth for a chip erase, or the last sector-erase command for a sector erase. Once the busy level falls, the next read returns array contents. For a finished program that read carries the true bit, and for a finished erase it reads 1s.

Top module: `op_status_flags`

## Requirements
- R1: When no operation is active (program busy, erase window, erase busy and latched failure all 0), rd_data_o equals array_data_i in the same cycle.
- R2: While a program operation is the active kind, rd_data_o[7] is the inverse of wr_data_i[7] as captured by the most recent clock edge on which wr_strobe_i was 1.
- R3: While an erase operation (window open or erase busy) is the active kind, rd_data_o[7] is 0 and rd_data_o[3] is 1. During programming, rd_data_o[3] is 0.
- R4: rd_data_o[6] is 0 in the first cycle of a new operation. A new operation is one whose kind differs from the previous cycle's kind, including a change from idle. On each clock edge where rd_strobe_i is 1 during the operation, the bit inverts. Without a read it holds.
- R5: A time_fail_i pulse during an operation sets rd_data_o[5] from the next cycle. Status reporting then continues with the same operation kind, and with the toggle still running, even after the engine's busy levels drop. It continues until a clock edge with reset_cmd_i equal to 1 ends it.
- R6: While status is reported, rd_data_o[4] and rd_data_o[2:0] are 0.
- R7: If program busy and an erase level are both 1, the erase kind takes precedence.
- R8: In the cycle in which the busy level of a normally completing operation falls, rd_data_o returns array_data_i, so the true value is read.
- R9: Asserting rst_ni low clears the latched failure, the toggle and the stored data bit asynchronously, giving pass-through at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_busy_i | input | 1 | Program engine running |
| erase_win_i | input | 1 | Sector-erase command window open |
| erase_busy_i | input | 1 | Erase engine running |
| time_fail_i | input | 1 | Engine exceeded its time limit (pulse) |
| reset_cmd_i | input | 1 | Reset command decoded |
| wr_strobe_i | input | 1 | Host write accepted this cycle |
| wr_data_i | input | DATA_W | Host write data |
| rd_strobe_i | input | 1 | Host read this cycle |
| array_data_i | input | DATA_W | Array read data |
| rd_data_o | output | DATA_W | Data returned to the host |

## Verification
The read path is combinational from registered state and the current inputs. A change in the engine levels therefore shows up in rd_data_o in the same cycle, while effects that are clocked in appear one edge later. Those are the toggle step after a read, the capture of the written bit, the setting of the failure flag and its clearing by the reset command. The bench drives every input at the falling edge and samples the output one nanosecond later, before the next rising edge. Each vector's expected byte therefore accounts for exactly the edges that have already passed. The asynchronous reset is checked without waiting for any edge.

// File: rtl/op_status_pkg.sv
package op_status_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_PROG  = 2'd1,
    KIND_ERASE = 2'd2
  } op_kind_e;

  localparam int unsigned POLL_BIT  = 7;
  localparam int unsigned TOG_BIT   = 6;
  localparam int unsigned FAIL_BIT  = 5;
  localparam int unsigned ERASE_BIT = 3;
endpackage

// File: rtl/op_tracker.sv
module op_status_tracker
  import op_status_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     prog_busy_i,
  input  logic     erase_win_i,
  input  logic     erase_busy_i,
  input  logic     time_fail_i,
  input  logic     reset_cmd_i,
  output op_kind_e kind_o,
  output logic     active_o,
  output logic     new_op_o,
  output logic     fail_o
);
  op_kind_e kind_q, prev_q;
  logic     fail_q;
  op_kind_e live_kind;

  // erase levels take precedence over program busy
  always_comb begin
    if (erase_win_i || erase_busy_i) live_kind = KIND_ERASE;
    else if (prog_busy_i)            live_kind = KIND_PROG;
    else                             live_kind = KIND_NONE;
  end

  assign kind_o   = fail_q ? kind_q : live_kind;
  assign active_o = (kind_o != KIND_NONE);
  assign new_op_o = active_o && (kind_o != prev_q);
  assign fail_o   = fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= KIND_NONE;
      prev_q <= KIND_NONE;
      fail_q <= 1'b0;
    end else begin
      prev_q <= kind_o;
      if (!fail_q) kind_q <= live_kind;
      if (reset_cmd_i)                 fail_q <= 1'b0;
      else if (time_fail_i && active_o) fail_q <= 1'b1;
    end
  end
endmodule

// File: rtl/op_toggle_gen.sv
module op_status_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic new_op_i,
  input  logic rd_strobe_i,
  output logic tog_o
);
  logic tog_q;

  assign tog_o = new_op_i ? 1'b0 : tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tog_q <= 1'b0;
    else if (!active_i)   tog_q <= 1'b0;
    else if (rd_strobe_i) tog_q <= ~tog_o;
    else                  tog_q <= tog_o;
  end
endmodule

// File: rtl/op_status_mux.sv
module op_status_mux
  import op_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  op_kind_e          kind_i,
  input  logic              tog_i,
  input  logic              fail_i,
  input  logic              last_bit_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] status;

  always_comb begin
    status            = '0;
    status[TOG_BIT]   = tog_i;
    status[FAIL_BIT]  = fail_i;
    status[ERASE_BIT] = (kind_i == KIND_ERASE);
    status[POLL_BIT]  = (kind_i == KIND_PROG) ? ~last_bit_i : 1'b0;
    rd_data_o = (kind_i == KIND_NONE) ? array_data_i : status;
  end
endmodule

// File: rtl/op_status_flags.sv
module op_status_flags
  import op_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_busy_i,
  input  logic              erase_win_i,
  input  logic              erase_busy_i,
  input  logic              time_fail_i,
  input  logic              reset_cmd_i,
  input  logic              wr_strobe_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_strobe_i,
  input  logic [DATA_W-1:0] array_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int unsigned MSB = DATA_W - 1;

  op_kind_e kind;
  logic     active, new_op, fail, tog, last_bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          last_bit_q <= 1'b0;
    else if (wr_strobe_i) last_bit_q <= wr_data_i[MSB];
  end

  op_status_tracker u_tracker (
    .clk_i, .rst_ni, .prog_busy_i, .erase_win_i, .erase_busy_i,
    .time_fail_i, .reset_cmd_i,
    .kind_o(kind), .active_o(active), .new_op_o(new_op), .fail_o(fail)
  );

  op_status_toggle u_toggle (
    .clk_i, .rst_ni, .active_i(active), .new_op_i(new_op),
    .rd_strobe_i, .tog_o(tog)
  );

  op_status_mux #(.DATA_W(DATA_W)) u_mux (
    .kind_i(kind), .tog_i(tog), .fail_i(fail), .last_bit_i(last_bit_q),
    .array_data_i, .rd_data_o
  );
endmodule

// File: rtl/op_status_flags_chk.sv
module op_status_flags_chk
  import op_status_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prog_busy_i,
  input logic              erase_win_i,
  input logic              erase_busy_i,
  input logic              reset_cmd_i,
  input logic              wr_strobe_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              rd_strobe_i,
  input logic [DATA_W-1:0] array_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input op_kind_e          kind,
  input logic              active,
  input logic              new_op,
  input logic              fail
);
  logic wbit_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          wbit_q <= 1'b0;
    else if (wr_strobe_i) wbit_q <= wr_data_i[DATA_W-1];
  end

  AST_IDLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> rd_data_o == array_data_i); // R1
  AST_PROG_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == KIND_PROG |-> rd_data_o[7] != wbit_q && !rd_data_o[3]); // R2
  AST_ERASE_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kind == KIND_ERASE |-> !rd_data_o[7] && rd_data_o[3]); // R3
  AST_TOG_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_op |-> !rd_data_o[6]); // R4
  AST_TOG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && rd_strobe_i) ##1 (active && !new_op) |-> rd_data_o[6] != $past(rd_data_o[6])); // R4
  AST_FAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail && !reset_cmd_i |=> active && rd_data_o[5]); // R5
  AST_ZERO_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> !rd_data_o[4] && rd_data_o[2:0] == 3'b000); // R6
  AST_ERASE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_i && (erase_win_i || erase_busy_i) |-> rd_data_o[3]); // R7
endmodule

bind op_status_flags op_status_flags_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i, .rst_ni, .prog_busy_i, .erase_win_i, .erase_busy_i, .reset_cmd_i,
  .wr_strobe_i, .wr_data_i, .rd_strobe_i, .array_data_i, .rd_data_o,
  .kind, .active, .new_op, .fail
);

// File: tb/op_status_flags_tb.sv
module op_status_flags_tb;
  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [7:0] wd;
    logic       prog, win, busy, tfail, rcmd, rd;
    logic [7:0] arr;
    logic [7:0] exp;
  } vec_t;

  localparam int NV = 23;
  // status byte: [7] poll, [6] toggle, [5] fail, [3] erase
  localparam vec_t VEC [NV] = '{
    '{4'd1, 1'b1, 8'hA5, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h3C, 8'h3C}, // R1 idle
    '{4'd2, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h00}, // R2 ~1, R4 start 0
    '{4'd4, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h40}, // R4
    '{4'd4, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 8'hFF, 8'h00},
    '{4'd4, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h00}, // no read -> held
    '{4'd8, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hA5, 8'hA5}, // R8 done
    '{4'd1, 1'b1, 8'h12, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 8'h12, 8'h12},
    '{4'd2, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h80}, // R2 ~0
    '{4'd4, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'hC0},
    '{4'd3, 1'b0, 8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h08}, // R3 window, new op
    '{4'd3, 1'b0, 8'h00, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h48},
    '{4'd3, 1'b0, 8'h00, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b1, 8'h00, 8'h08}, // same erase op
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 8'h00, 8'h48},
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h68}, // R5 held
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h28},
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 8'hFF, 8'h68},
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'hFF}, // cleared
    '{4'd2, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'h80},
    '{4'd5, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 8'hFF, 8'hC0},
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'hFF, 8'hE0}, // prog kind kept
    '{4'd5, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 8'hFF, 8'hA0},
    '{4'd6, 1'b0, 8'h00, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 8'h5A, 8'h5A}, // R6 zeros shown above
    '{4'd7, 1'b0, 8'h00, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 8'h00, 8'h08}  // R7
  };

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       prog_busy_i = 0, erase_win_i = 0, erase_busy_i = 0;
  logic       time_fail_i = 0, reset_cmd_i = 0, wr_strobe_i = 0, rd_strobe_i = 0;
  logic [7:0] wr_data_i = '0, array_data_i = '0, rd_data_o;
  int         n_run = 0, n_fail = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  op_status_flags u_dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    wr_strobe_i = v.wr;  wr_data_i = v.wd;
    prog_busy_i = v.prog; erase_win_i = v.win; erase_busy_i = v.busy;
    time_fail_i = v.tfail; reset_cmd_i = v.rcmd; rd_strobe_i = v.rd;
    array_data_i = v.arr;
  endtask

  initial begin
    array_data_i = 8'h77;
    #1 check("R9", rd_data_o, 8'h77);
    @(negedge clk_i); rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VEC[i]);
      #1 check($sformatf("R%0d vec %0d", VEC[i].req, i), rd_data_o, VEC[i].exp);
    end
    // R9: async reset while a failure is latched
    @(negedge clk_i);
    drive('{4'd9, 1'b0, 8'h00, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b1, 8'h11, 8'h00});
    @(negedge clk_i);
    prog_busy_i = 0; time_fail_i = 0; rd_strobe_i = 0;
    #1 check("R5 latched", rd_data_o, 8'hE0);
    rst_ni = 1'b0;
    #1 check("R9 async", rd_data_o, 8'h11);
    @(negedge clk_i); rst_ni = 1'b1;
    // R4: toggle starts at 0 after reset
    @(negedge clk_i); erase_busy_i = 1;
    #1 check("R4 after reset", rd_data_o, 8'h08);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (200000) @(posedge clk_i); end
    join_any
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule